// File: doc/BRIEF.md
# Usage-History Fault Isolation Grid

This block narrows down the location of a single stuck-at faulty resource in a grid of ROWS by COLS resources. No test vectors are used. Two competing configurations run side by side, and each exposes a usage mask that marks the resources it occupies. Whenever their outputs disagree, the caller presents both masks, a discrepancy flag and the identity of the losing configuration. The block adds one to a per-resource history counter at every position that the loser's mask marks. Over many comparisons the faulty resource builds up the highest count, because it lies in the intersection of the losing configurations.

After each accepted comparison the block walks the whole history grid once, one resource per clock cycle. It finds the current maximum count, the number of resources that hold that maximum (the suspect set), and the first of them in row-major order. When the suspect set has shrunk to a single entry, the block reports isolation. When the suspect-set size stays the same for a set number of consecutive results, the block issues a one-cycle request to the configuration manager to swap half of the used columns for unused ones. A clear input wipes the whole history.

Top module: `fault_isolator`

## Requirements
- R1: After reset, and after any cycle with clearHist high, all history counters are zero and the block is idle (busy low), with suspRow, suspCol, suspCount, isolated, resultValid and halveReq all at 0.
- R2: A comparison is accepted on a rising edge where cmpValid and discrepant are high, busy is low and clearHist is low. On that edge every counter whose mask bit is 1 increments by one. The mask used is maskB when loserB is 1 and maskA when loserB is 0. Mask bit index row*COLS+col belongs to the resource at (row, col).
- R3: A comparison offered with discrepant low changes no counter, does not raise busy and leaves all result outputs unchanged.
- R4: A comparison offered while busy is high is ignored and has no effect on the counters.
- R5: Each counter saturates at 2^CNT_W-1, and further increments leave it there.
- R6: After an accepted comparison, busy is high for exactly ROWS*COLS cycles. resultValid is a one-cycle pulse in the cycle that follows the ROWS*COLS-th rising edge after the accepting edge.
- R7: With each result, suspCount gives the number of resources whose count equals the grid maximum. suspRow and suspCol give the lowest row-major position that holds that maximum.
- R8: isolated is 1 exactly when the reported suspCount equals 1.
- R9: The stall count goes up by one for each result whose suspCount equals that of the previous result and is not 1; any other result sets it back to zero. When the stall count reaches STASIS_LIM, halveReq pulses for one cycle in the cycle after that resultValid, and the stall count restarts from zero. The first result after reset or clear never counts as a repeat.
- R10: clearHist takes priority: it aborts a scan in progress, so that no resultValid follows, and it overrides a comparison offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| clearHist | input | 1 | Clears the history grid and the stasis state, and aborts any scan |
| cmpValid | input | 1 | A comparison outcome is offered |
| discrepant | input | 1 | The two configurations disagreed |
| loserB | input | 1 | 1: configuration B lost, 0: configuration A lost |
| maskA | input | ROWS*COLS | Usage mask of configuration A, bit row*COLS+col |
| maskB | input | ROWS*COLS | Usage mask of configuration B, bit row*COLS+col |
| busy | output | 1 | A scan of the grid is in progress |
| resultValid | output | 1 | One-cycle pulse when new results are on the outputs |
| suspRow | output | clog2(ROWS) | Row of the first maximum-count resource |
| suspCol | output | clog2(COLS) | Column of the first maximum-count resource |
| suspCount | output | clog2(ROWS*COLS+1) | Size of the suspect set |
| isolated | output | 1 | The suspect set holds exactly one resource |
| halveReq | output | 1 | One-cycle request for a column-halving step |

## Verification
The counters change on the accepting edge. The scan results, together with resultValid, appear ROWS*COLS rising edges later, and halveReq follows one edge after that. The bench drives inputs on falling edges and counts exactly that many rising edges before it samples on the next falling edge. It checks resultValid high at the result cycle and low one cycle later, and checks halveReq in that later cycle. For an ignored or cleared comparison, the bench samples busy on the falling edge right after the offering edge. It then reads the effect on the history through the next scan's results.

// File: rtl/fiso_pkg.sv
package fiso_pkg;
  // Strobes the control issues to the datapath each cycle.
  typedef struct packed {
    logic clr;    // wipe history and results
    logic incr;   // apply the loser mask to the counters
    logic step;   // examine one resource of the scan
    logic first;  // this step is the first of the scan
    logic last;   // this step is the last of the scan
  } fisoStrobe_t;
endpackage

// File: rtl/fiso_cell.sv
module fiso_cell #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && (count != CNT_MAX)) begin
      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/fiso_datapath.sv
module fiso_datapath
  import fiso_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int CNT_W = 4,
  localparam int CELLS  = ROWS * COLS,
  localparam int IDX_W  = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CNTS_W = $clog2(CELLS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fisoStrobe_t       strobe,
  input  logic              loserB,
  input  logic [CELLS-1:0]  maskA,
  input  logic [CELLS-1:0]  maskB,
  input  logic [IDX_W-1:0]  scanIdx,
  input  logic [ROW_W-1:0]  scanRow,
  input  logic [COL_W-1:0]  scanCol,
  output logic [ROW_W-1:0]  suspRow,
  output logic [COL_W-1:0]  suspCol,
  output logic [CNTS_W-1:0] suspCount,
  output logic              isolated
);
  logic [CELLS-1:0] incMask;
  logic [CNT_W-1:0] hist [CELLS];

  assign incMask = loserB ? maskB : maskA;

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    fiso_cell #(.CNT_W(CNT_W)) u_cell (
      .clk   (clk),
      .rstN  (rstN),
      .clr   (strobe.clr),
      .inc   (strobe.incr & incMask[g]),
      .count (hist[g])
    );
  end

  // Running maximum and tie count across the scan.
  logic [CNT_W-1:0]  runMax, nxtMax, cur;
  logic [CNTS_W-1:0] runCnt, nxtCnt;
  logic [ROW_W-1:0]  runRow, nxtRow;
  logic [COL_W-1:0]  runCol, nxtCol;

  assign cur = hist[scanIdx];

  always_comb begin
    nxtMax = runMax;
    nxtCnt = runCnt;
    nxtRow = runRow;
    nxtCol = runCol;
    if (strobe.first || (cur > runMax)) begin
      nxtMax = cur;
      nxtCnt = CNTS_W'(1);
      nxtRow = scanRow;
      nxtCol = scanCol;
    end else if (cur == runMax) begin
      nxtCnt = runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runMax    <= '0;
      runCnt    <= '0;
      runRow    <= '0;
      runCol    <= '0;
      suspRow   <= '0;
      suspCol   <= '0;
      suspCount <= '0;
      isolated  <= 1'b0;
    end else if (strobe.clr) begin
      runMax    <= '0;
      runCnt    <= '0;
      runRow    <= '0;
      runCol    <= '0;
      suspRow   <= '0;
      suspCol   <= '0;
      suspCount <= '0;
      isolated  <= 1'b0;
    end else if (strobe.step) begin
      runMax <= nxtMax;
      runCnt <= nxtCnt;
      runRow <= nxtRow;
      runCol <= nxtCol;
      if (strobe.last) begin
        suspRow   <= nxtRow;
        suspCol   <= nxtCol;
        suspCount <= nxtCnt;
        isolated  <= (nxtCnt == CNTS_W'(1));
      end
    end
  end
endmodule

// File: rtl/fiso_control.sv
module fiso_control
  import fiso_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int STASIS_LIM = 3,
  localparam int CELLS   = ROWS * COLS,
  localparam int IDX_W   = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CNTS_W  = $clog2(CELLS + 1),
  localparam int STALL_W = $clog2(STASIS_LIM + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clearHist,
  input  logic              cmpValid,
  input  logic              discrepant,
  input  logic [CNTS_W-1:0] suspCount,
  output fisoStrobe_t       strobe,
  output logic [IDX_W-1:0]  scanIdx,
  output logic [ROW_W-1:0]  scanRow,
  output logic [COL_W-1:0]  scanCol,
  output logic              busy,
  output logic              resultValid,
  output logic              halveReq
);
  typedef enum logic {ST_IDLE, ST_SCAN} state_t;
  state_t state;

  logic               accept;
  logic [CNTS_W-1:0]  prevCount;
  logic [STALL_W-1:0] stallCnt;

  assign busy   = (state == ST_SCAN);
  assign accept = !clearHist && (state == ST_IDLE) && cmpValid && discrepant;

  always_comb begin
    strobe.clr   = clearHist;
    strobe.incr  = accept;
    strobe.step  = busy && !clearHist;
    strobe.first = strobe.step && (scanIdx == '0);
    strobe.last  = strobe.step && (scanIdx == IDX_W'(CELLS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      scanIdx     <= '0;
      scanRow     <= '0;
      scanCol     <= '0;
      resultValid <= 1'b0;
      halveReq    <= 1'b0;
      prevCount   <= '0;
      stallCnt    <= '0;
    end else if (clearHist) begin
      state       <= ST_IDLE;
      scanIdx     <= '0;
      scanRow     <= '0;
      scanCol     <= '0;
      resultValid <= 1'b0;
      halveReq    <= 1'b0;
      prevCount   <= '0;
      stallCnt    <= '0;
    end else begin
      resultValid <= strobe.last;
      halveReq    <= 1'b0;

      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_SCAN;
            scanIdx <= '0;
            scanRow <= '0;
            scanCol <= '0;
          end
        end
        ST_SCAN: begin
          scanIdx <= scanIdx + 1'b1;
          if (scanCol == COL_W'(COLS - 1)) begin
            scanCol <= '0;
            scanRow <= scanRow + 1'b1;
          end else begin
            scanCol <= scanCol + 1'b1;
          end
          if (strobe.last) begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase

      // Stasis tracking on each freshly published result.
      if (resultValid) begin
        prevCount <= suspCount;
        if ((suspCount == prevCount) && (suspCount != CNTS_W'(1))) begin
          if (stallCnt == STALL_W'(STASIS_LIM - 1)) begin
            halveReq <= 1'b1;
            stallCnt <= '0;
          end else begin
            stallCnt <= stallCnt + 1'b1;
          end
        end else begin
          stallCnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/fault_isolator.sv
module fault_isolator
  import fiso_pkg::*;
#(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int CNT_W      = 4,
  parameter int STASIS_LIM = 3
) (
  input  logic                                    clk,
  input  logic                                    rstN,
  input  logic                                    clearHist,
  input  logic                                    cmpValid,
  input  logic                                    discrepant,
  input  logic                                    loserB,
  input  logic [ROWS*COLS-1:0]                    maskA,
  input  logic [ROWS*COLS-1:0]                    maskB,
  output logic                                    busy,
  output logic                                    resultValid,
  output logic [((ROWS > 1) ? $clog2(ROWS) : 1)-1:0] suspRow,
  output logic [((COLS > 1) ? $clog2(COLS) : 1)-1:0] suspCol,
  output logic [$clog2(ROWS*COLS+1)-1:0]          suspCount,
  output logic                                    isolated,
  output logic                                    halveReq
);
  localparam int CELLS = ROWS * COLS;
  localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1;

  fisoStrobe_t      strobe;
  logic [IDX_W-1:0] scanIdx;
  logic [ROW_W-1:0] scanRow;
  logic [COL_W-1:0] scanCol;

  fiso_control #(
    .ROWS(ROWS), .COLS(COLS), .STASIS_LIM(STASIS_LIM)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .clearHist   (clearHist),
    .cmpValid    (cmpValid),
    .discrepant  (discrepant),
    .suspCount   (suspCount),
    .strobe      (strobe),
    .scanIdx     (scanIdx),
    .scanRow     (scanRow),
    .scanCol     (scanCol),
    .busy        (busy),
    .resultValid (resultValid),
    .halveReq    (halveReq)
  );

  fiso_datapath #(
    .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loserB    (loserB),
    .maskA     (maskA),
    .maskB     (maskB),
    .scanIdx   (scanIdx),
    .scanRow   (scanRow),
    .scanCol   (scanCol),
    .suspRow   (suspRow),
    .suspCol   (suspCol),
    .suspCount (suspCount),
    .isolated  (isolated)
  );
endmodule

// File: rtl/fault_isolator_chk.sv
module fault_isolator_chk #(
  parameter int ROWS       = 4,
  parameter int COLS       = 4,
  parameter int CNT_W      = 4,
  parameter int STASIS_LIM = 3,
  localparam int CELLS  = ROWS * COLS,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CNTS_W = $clog2(CELLS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              clearHist,
  input logic              busy,
  input logic              resultValid,
  input logic [ROW_W-1:0]  suspRow,
  input logic [COL_W-1:0]  suspCol,
  input logic [CNTS_W-1:0] suspCount,
  input logic              isolated,
  input logic              halveReq
);
  // Length of the current busy stretch, to check the scan window.
  int unsigned busyLen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyLen <= 0;
    else if (busy) busyLen <= busyLen + 1;
    else           busyLen <= 0;
  end

  AST_SCAN_LEN: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(clearHist)) |-> (busyLen == CELLS)); // R6
  AST_RESULT_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && !$past(clearHist)) |-> resultValid); // R6
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(busy) && !$past(clearHist)) |-> $stable(suspCount)); // R3
  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> ((suspRow < ROWS) && (suspCol < COLS) && (suspCount != 0))); // R7
  AST_HALVE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    halveReq |=> !halveReq); // R9
  AST_HALVE_AFTER_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    halveReq |-> ($past(resultValid) && !isolated)); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearHist) |-> (!busy && (suspCount == 0) && !resultValid)); // R10
endmodule

bind fault_isolator fault_isolator_chk #(
  .ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .STASIS_LIM(STASIS_LIM)
) u_chk (
  .clk(clk), .rstN(rstN), .clearHist(clearHist), .busy(busy),
  .resultValid(resultValid), .suspRow(suspRow), .suspCol(suspCol),
  .suspCount(suspCount), .isolated(isolated), .halveReq(halveReq)
);

// File: tb/fault_isolator_bench.sv
`timescale 1ns/1ps
module fault_isolator_bench;
  localparam int ROWS = 4, COLS = 4, CNT_W = 4, LIM = 3;
  localparam int CELLS = ROWS * COLS;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int FAULT = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearHist = 1'b0, cmpValid = 1'b0, discrepant = 1'b0, loserB = 1'b0;
  logic [CELLS-1:0] maskA = '0, maskB = '0;
  logic busy, resultValid, isolated, halveReq;
  logic [1:0] suspRow, suspCol;
  logic [4:0] suspCount;

  fault_isolator #(.ROWS(ROWS), .COLS(COLS), .CNT_W(CNT_W), .STASIS_LIM(LIM))
  u_fault_isolator (
    .clk(clk), .rstN(rstN), .clearHist(clearHist), .cmpValid(cmpValid),
    .discrepant(discrepant), .loserB(loserB), .maskA(maskA), .maskB(maskB),
    .busy(busy), .resultValid(resultValid), .suspRow(suspRow), .suspCol(suspCol),
    .suspCount(suspCount), .isolated(isolated), .halveReq(halveReq)
  );

  always #4 clk = ~clk;  // 125 MHz

  int nChk = 0, nFail = 0;
  int hist [CELLS];
  int expRow = 0, expCol = 0, expCnt = 0, expIso = 0, prevCnt = 0, stall = 0;
  int expHalve = 0;
  bit done = 1'b0;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void mClear();
    for (int i = 0; i < CELLS; i++) hist[i] = 0;
    expRow = 0; expCol = 0; expCnt = 0; expIso = 0;
    prevCnt = 0; stall = 0; expHalve = 0;
  endfunction

  function automatic void mApply(logic [CELLS-1:0] m);
    for (int i = 0; i < CELLS; i++)
      if (m[i] && hist[i] < CMAX) hist[i]++;
  endfunction

  function automatic void mScan();
    int mx = -1;
    int cnt = 0;
    for (int i = 0; i < CELLS; i++) begin
      if (hist[i] > mx) begin
        mx = hist[i]; cnt = 1; expRow = i / COLS; expCol = i % COLS;
      end else if (hist[i] == mx) begin
        cnt++;
      end
    end
    expCnt = cnt;
    expIso = (cnt == 1) ? 1 : 0;
    expHalve = 0;
    if (cnt == prevCnt && cnt != 1) begin
      stall++;
      if (stall == LIM) begin expHalve = 1; stall = 0; end
    end else begin
      stall = 0;
    end
    prevCnt = cnt;
  endfunction

  task automatic issue(logic [CELLS-1:0] a, logic [CELLS-1:0] b, logic lb, logic d);
    @(negedge clk);
    maskA = a; maskB = b; loserB = lb; discrepant = d; cmpValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmpValid = 1'b0; discrepant = 1'b0;
  endtask

  task automatic finishScan(int edges);
    repeat (edges) @(posedge clk);
    @(negedge clk);
    mScan();
    chk("R6 resultValid at end of scan", int'(resultValid), 1);
    chk("R7 suspRow", int'(suspRow), expRow);
    chk("R7 suspCol", int'(suspCol), expCol);
    chk("R7 suspCount", int'(suspCount), expCnt);
    chk("R8 isolated", int'(isolated), expIso);
    @(posedge clk);
    @(negedge clk);
    chk("R9 halveReq", int'(halveReq), expHalve);
    chk("R6 resultValid single pulse", int'(resultValid), 0);
  endtask

  task automatic runCmp(logic [CELLS-1:0] a, logic [CELLS-1:0] b, logic lb);
    mApply(lb ? b : a);
    issue(a, b, lb, 1'b1);
    chk("R6 busy after accept", int'(busy), 1);
    finishScan(CELLS);
  endtask

  task automatic doClear();
    @(negedge clk);
    clearHist = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clearHist = 1'b0;
    mClear();
    chk("R1 busy after clear", int'(busy), 0);
    chk("R1 suspCount after clear", int'(suspCount), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    mClear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 suspCount", int'(suspCount), 0);
    chk("R1 isolated", int'(isolated), 0);
    chk("R1 halveReq", int'(halveReq), 0);
    chk("R1 resultValid", int'(resultValid), 0);

    // R2 loser select: A loses with {0,5,10}, decoy B all ones
    runCmp(16'h0421, 16'hFFFF, 1'b0);
    // R2 B loses with {5,6}, decoy A all ones -> (1,1) isolated
    runCmp(16'hFFFF, 16'h0060, 1'b1);

    // R3 non-discrepant comparison ignored
    issue(16'hFFFF, 16'hFFFF, 1'b0, 1'b0);
    chk("R3 no scan started", int'(busy), 0);
    chk("R3 result held", int'(suspCount), expCnt);

    // R4 comparison offered during a scan is ignored
    mApply(16'h0020);
    issue(16'h0020, 16'h0000, 1'b0, 1'b1);
    maskA = 16'h0002; loserB = 1'b0; discrepant = 1'b1; cmpValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmpValid = 1'b0; discrepant = 1'b0;
    finishScan(CELLS - 1);

    // R10 clear aborts a running scan
    issue(16'h00F0, 16'h0000, 1'b0, 1'b1);
    repeat (3) @(posedge clk);
    doClear();
    begin
      int sawRv = 0;
      for (int k = 0; k < CELLS + 2; k++) begin
        @(negedge clk);
        if (resultValid) sawRv = 1;
      end
      chk("R10 no result after abort", sawRv, 0);
    end
    // R10 clear overrides simultaneous comparison
    @(negedge clk);
    clearHist = 1'b1; cmpValid = 1'b1; discrepant = 1'b1; maskA = 16'hFFFF; loserB = 1'b0;
    @(posedge clk);
    @(negedge clk);
    clearHist = 1'b0; cmpValid = 1'b0; discrepant = 1'b0;
    mClear();
    chk("R10 comparison dropped under clear", int'(busy), 0);
    runCmp(16'h8000, 16'h0001, 1'b0);  // clean history -> (3,3)

    // R9 stasis: same two-resource mask repeatedly, requests on 4th and 7th
    doClear();
    for (int k = 0; k < 7; k++) runCmp(16'h0006, 16'h0000, 1'b0);

    // R5 saturation: 20 all-ones, then one more on resource 4
    doClear();
    for (int k = 0; k < 20; k++) runCmp(16'hFFFF, 16'h0000, 1'b0);
    runCmp(16'h0010, 16'h0000, 1'b0);
    chk("R5 all counters saturated equal", int'(suspCount), CELLS);

    // Random comparisons around a fixed faulty resource
    doClear();
    for (int it = 0; it < 40; it++) begin
      logic [CELLS-1:0] a, b;
      logic lb;
      a = CELLS'($urandom);
      b = CELLS'($urandom);
      if (!a[FAULT] && !b[FAULT]) begin
        issue(a, b, 1'b0, 1'b0);
        chk("R3 no fault articulated", int'(busy), 0);
      end else begin
        if (a[FAULT] && b[FAULT]) lb = 1'($urandom % 2);
        else lb = b[FAULT];
        runCmp(a, b, lb);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule